// File: doc/BRIEF.md
# Firmware Bus Memory Cycle Target

This block is the target side of a 4-bit multiplexed firmware bus. It runs on the bus clock and watches the active-low frame strobe together with the shared nibble bus. From the START nibble it tells apart two framings that share the pins. One is a firmware-hub memory cycle, which carries an ID-select nibble, a 7-nibble address and a size nibble. The other is a plain low-pin-count memory cycle, which carries a cycle-type nibble and an 8-nibble address.

Once the block has the address, and any write data, it issues one request on a simple internal memory port. It then takes over the bus for turnaround, sync and read-data nibbles. When it is not in one of its own drive phases it releases the bus. If the host pulls the frame strobe low again at any point, the current transfer is dropped and decoding restarts from the new START nibble.

Top module: `lpc_fwh_target`

## Requirements
- R1: While reset is held and after it is released, the target does not drive the bus (`bus_oe`=0) and raises no memory request.
- R2: A firmware-hub cycle starts with START 1101b (read) or 1110b (write). The nibble after START must equal `strap_id`. If it does not, the cycle is ignored: no request is made and the bus is not driven.
- R3: A low-pin-count cycle starts with START 0000b. The next nibble must be 0100b (memory read) or 0110b (memory write). Any other cycle-type nibble, and any other START value, sends the block idle until the next frame.
- R4: Address nibbles arrive most significant first: 7 of them for firmware-hub cycles, zero-extended to 32 bits, and 8 for low-pin-count cycles. `mem_req` is high for exactly one clock, the clock after the last host nibble. In that clock `mem_addr`, `mem_we` and `mem_size` are valid.
- R5: The firmware-hub size nibble 0000b, 0001b or 0010b selects 1, 2 or 4 bytes, and `mem_size` shows bytes-1 (0, 1 or 3). Any other size code makes the block ignore the cycle. Low-pin-count cycles are always 1 byte.
- R6: Write data arrives low nibble first. Byte k lands in `mem_wdata[8k+7:8k]`, giving 2, 4 or 8 data nibbles.
- R7: The first turnaround clock (the request clock) is left undriven. The target drives 1111b in the second one.
- R8: Sync is 0101b (wait) until read data is valid, then 0000b (ready). A low-pin-count read gives at least two wait nibbles. Writes report ready in the first sync clock.
- R9: After ready, a read returns its bytes low nibble first. Every cycle then ends with one driven 1111b clock, and the bus is released in the clock after it.
- R10: Frame low aborts the current transfer. The bus is released in the same clock, and the nibble sampled with the frame low is taken as a new START.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low frame strobe from the host |
| bus_in | input | 4 | Nibble seen on the shared bus |
| bus_out | output | 4 | Nibble the target drives |
| bus_oe | output | 1 | Target drive enable for the shared bus |
| strap_id | input | 4 | Strapped device ID for firmware-hub select |
| mem_req | output | 1 | One-clock memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request byte address |
| mem_size | output | 2 | Number of bytes minus one (0, 1 or 3) |
| mem_wdata | output | 32 | Write data, byte 0 in the low bits |
| mem_rvalid | input | 1 | Read data valid strobe |
| mem_rdata | input | 32 | Read data, byte 0 in the low bits |

## Verification
A wrong nibble count or a mis-decoded START shows up as `mem_req` appearing in the wrong clock, or with a shifted `mem_addr`, by the end of the address phase of that same cycle. A wrong wait count or wrong turnaround sequencing shows as a misplaced 0101b, 0000b or 1111b nibble within a few clocks of the request. Memory latency is varied so that the wait path runs both with and without its low-pin-count minimum. Ignored cycles and aborts are checked by watching that `bus_oe` and `mem_req` stay low, and that the next frame is decoded correctly.

// File: rtl/lpc_fwh_pkg.sv
package lpc_fwh_pkg;
    localparam int NIB_W         = 4;
    localparam int ADDR_W        = 32;
    localparam int DATA_W        = 32;
    localparam int FWH_ADDR_NIBS = 7;
    localparam int LPC_ADDR_NIBS = 8;
    localparam int LPC_MIN_WAITS = 2;
    localparam int CNT_W         = $clog2(DATA_W / NIB_W);
    localparam int WAIT_W        = $clog2(LPC_MIN_WAITS + 1);

    localparam logic [NIB_W-1:0] START_FWH_RD = 4'b1101;
    localparam logic [NIB_W-1:0] START_FWH_WR = 4'b1110;
    localparam logic [NIB_W-1:0] START_LPC    = 4'b0000;
    localparam logic [NIB_W-1:0] TYPE_MEM_RD  = 4'b0100;
    localparam logic [NIB_W-1:0] TYPE_MEM_WR  = 4'b0110;
    localparam logic [NIB_W-1:0] SYNC_READY   = 4'b0000;
    localparam logic [NIB_W-1:0] SYNC_WAIT    = 4'b0101;
    localparam logic [NIB_W-1:0] NIB_TAR      = 4'b1111;

    typedef enum logic [3:0] {
        S_IDLE, S_START, S_ADDR, S_SIZE, S_DATA,
        S_TAR1, S_TAR2, S_SYNC, S_RDATA, S_TAR3
    } state_e;

    typedef enum logic [2:0] {
        K_NONE, K_FWH_RD, K_FWH_WR, K_LPC_RD, K_LPC_WR
    } kind_e;

    typedef struct packed {
        state_e              st;
        logic [NIB_W-1:0]    start;
        logic                fwh;
        logic                wr;
        logic [ADDR_W-1:0]   addr;
        logic [CNT_W-1:0]    cnt;
        logic [1:0]          nb;
        logic [DATA_W-1:0]   data;
        logic                have;
        logic [WAIT_W-1:0]   waits;
    } regs_t;
endpackage

// File: rtl/lpc_fwh_start_decode.sv
module lpc_fwh_start_decode
    import lpc_fwh_pkg::*;
(
    input  logic [NIB_W-1:0] start_nib,
    input  logic [NIB_W-1:0] next_nib,
    input  logic [NIB_W-1:0] strap_id,
    output kind_e            kind
);
    always_comb begin
        kind = K_NONE;
        unique case (start_nib)
            START_FWH_RD: if (next_nib == strap_id) kind = K_FWH_RD;
            START_FWH_WR: if (next_nib == strap_id) kind = K_FWH_WR;
            START_LPC: begin
                if (next_nib == TYPE_MEM_RD)      kind = K_LPC_RD;
                else if (next_nib == TYPE_MEM_WR) kind = K_LPC_WR;
            end
            default: kind = K_NONE;
        endcase
    end
endmodule

// File: rtl/lpc_fwh_size_decode.sv
module lpc_fwh_size_decode
    import lpc_fwh_pkg::*;
(
    input  logic [NIB_W-1:0] size_nib,
    output logic             size_ok,
    output logic [1:0]       size_nb
);
    always_comb begin
        size_ok = 1'b1;
        size_nb = 2'd0;
        unique case (size_nib)
            4'b0000: size_nb = 2'd0;
            4'b0001: size_nb = 2'd1;
            4'b0010: size_nb = 2'd3;
            default: size_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/lpc_fwh_target.sv
module lpc_fwh_target
    import lpc_fwh_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic [NIB_W-1:0]  bus_in,
    output logic [NIB_W-1:0]  bus_out,
    output logic              bus_oe,
    input  logic [NIB_W-1:0]  strap_id,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [1:0]        mem_size,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);
    regs_t q, d;
    kind_e kind;
    logic  size_ok;
    logic [1:0] size_nb;
    logic  sync_go;
    logic  drive;
    logic [CNT_W-1:0] last_idx;

    lpc_fwh_start_decode u_start (
        .start_nib (q.start),
        .next_nib  (bus_in),
        .strap_id  (strap_id),
        .kind      (kind)
    );

    lpc_fwh_size_decode u_size (
        .size_nib (bus_in),
        .size_ok  (size_ok),
        .size_nb  (size_nb)
    );

    assign last_idx = CNT_W'({q.nb, 1'b1});
    assign sync_go  = q.wr || (q.have && (q.fwh || q.waits == WAIT_W'(LPC_MIN_WAITS)));

    always_comb begin
        d = q;
        if (!frame_n) begin
            d.st    = S_START;
            d.start = bus_in;
        end else begin
            unique case (q.st)
                S_START: begin
                    d.fwh   = (kind == K_FWH_RD) || (kind == K_FWH_WR);
                    d.wr    = (kind == K_FWH_WR) || (kind == K_LPC_WR);
                    d.addr  = '0;
                    d.data  = '0;
                    d.nb    = 2'd0;
                    d.have  = 1'b0;
                    d.waits = '0;
                    d.cnt   = d.fwh ? CNT_W'(FWH_ADDR_NIBS - 1) : CNT_W'(LPC_ADDR_NIBS - 1);
                    d.st    = (kind == K_NONE) ? S_IDLE : S_ADDR;
                end
                S_ADDR: begin
                    d.addr = {q.addr[ADDR_W-NIB_W-1:0], bus_in};
                    if (q.cnt == '0) begin
                        d.cnt = '0;
                        if (q.fwh)     d.st = S_SIZE;
                        else if (q.wr) d.st = S_DATA;
                        else           d.st = S_TAR1;
                    end else begin
                        d.cnt = q.cnt - 1'b1;
                    end
                end
                S_SIZE: begin
                    if (size_ok) begin
                        d.nb = size_nb;
                        d.st = q.wr ? S_DATA : S_TAR1;
                    end else begin
                        d.st = S_IDLE;
                    end
                end
                S_DATA: begin
                    d.data[{q.cnt, 2'b00} +: NIB_W] = bus_in;
                    if (q.cnt == last_idx) d.st = S_TAR1;
                    else                   d.cnt = q.cnt + 1'b1;
                end
                S_TAR1, S_TAR2, S_SYNC: begin
                    if (!q.wr && !q.have && mem_rvalid) begin
                        d.data = mem_rdata;
                        d.have = 1'b1;
                    end
                    if (q.st == S_TAR1)      d.st = S_TAR2;
                    else if (q.st == S_TAR2) d.st = S_SYNC;
                    else if (sync_go) begin
                        d.st  = q.wr ? S_TAR3 : S_RDATA;
                        d.cnt = '0;
                    end else if (q.waits != WAIT_W'(LPC_MIN_WAITS)) begin
                        d.waits = q.waits + 1'b1;
                    end
                end
                S_RDATA: begin
                    if (q.cnt == last_idx) d.st = S_TAR3;
                    else                   d.cnt = q.cnt + 1'b1;
                end
                S_TAR3:  d.st = S_IDLE;
                default: d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        drive   = 1'b0;
        bus_out = NIB_TAR;
        unique case (q.st)
            S_TAR2, S_TAR3: drive = 1'b1;
            S_SYNC: begin
                drive   = 1'b1;
                bus_out = sync_go ? SYNC_READY : SYNC_WAIT;
            end
            S_RDATA: begin
                drive   = 1'b1;
                bus_out = q.data[{q.cnt, 2'b00} +: NIB_W];
            end
            default: drive = 1'b0;
        endcase
    end

    assign bus_oe    = drive && frame_n;
    assign mem_req   = (q.st == S_TAR1);
    assign mem_we    = q.wr;
    assign mem_addr  = q.addr;
    assign mem_size  = q.nb;
    assign mem_wdata = q.data;
endmodule

// File: rtl/lpc_fwh_target_chk.sv
module lpc_fwh_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_n,
    input logic [3:0] bus_out,
    input logic       bus_oe,
    input logic       mem_req,
    input logic       mem_we
);
    // R10
    oe_off_on_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |-> !bus_oe);

    // R4
    req_single_clock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R7
    tar_first_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !bus_oe);

    // R7
    tar_second_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && frame_n) |=> (!frame_n || (bus_oe && bus_out == 4'b1111)));

    // R8
    write_sync_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(mem_req && mem_we, 2) && $past(frame_n, 1) && $past(frame_n, 2))
        |-> bus_out == 4'b0000);
endmodule

bind lpc_fwh_target lpc_fwh_target_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .frame_n (frame_n),
    .bus_out (bus_out),
    .bus_oe  (bus_oe),
    .mem_req (mem_req),
    .mem_we  (mem_we)
);

// File: tb/lpc_fwh_target_test.sv
module lpc_fwh_target_test;
    localparam int CLK_P   = 30;
    localparam logic [3:0] STRAP = 4'hA;
    localparam int NVEC = 9;
    // {fwh, wr, size code[1:0], latency[3:0], addr[31:0], wdata[31:0]}
    localparam logic [71:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 2'd0, 4'd0, 32'h0123_4567, 32'h0},
        {1'b1, 1'b0, 2'd1, 4'd3, 32'h0ABC_DEF0, 32'h0},
        {1'b1, 1'b0, 2'd2, 4'd1, 32'h0000_1004, 32'h0},
        {1'b1, 1'b1, 2'd0, 4'd0, 32'h0765_4321, 32'h0000_005A},
        {1'b1, 1'b1, 2'd2, 4'd0, 32'h0FFF_FFFC, 32'hDEAD_BEEF},
        {1'b1, 1'b1, 2'd1, 4'd0, 32'h0000_0002, 32'h0000_C3A1},
        {1'b0, 1'b0, 2'd0, 4'd0, 32'hFFBF_0010, 32'h0},
        {1'b0, 1'b0, 2'd0, 4'd5, 32'h8000_0001, 32'h0},
        {1'b0, 1'b1, 2'd0, 4'd0, 32'h1234_ABCD, 32'h0000_0096}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic frame_n = 1'b1;
    logic [3:0] bus_in = 4'hF;
    logic [3:0] bus_out;
    logic bus_oe;
    logic [3:0] strap_id = STRAP;
    logic mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [1:0] mem_size;
    logic mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;

    int checks = 0;
    int fails = 0;
    int lat_cfg = 0;
    int pend = 0;

    always #(CLK_P/2) clk = ~clk;

    lpc_fwh_target uut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .bus_in(bus_in),
        .bus_out(bus_out), .bus_oe(bus_oe), .strap_id(strap_id),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_size(mem_size), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] model(input logic [31:0] a);
        return 32'h5A3C_96E1 ^ {a[15:0], a[15:0]};
    endfunction

    // memory model: data valid 'lat_cfg' clocks after the request clock
    always @(negedge clk) begin
        mem_rvalid = 1'b0;
        if (mem_req && !mem_we) begin
            mem_rdata = model(mem_addr);
            if (lat_cfg == 0) mem_rvalid = 1'b1;
            else pend = lat_cfg;
        end else if (pend > 0) begin
            pend = pend - 1;
            if (pend == 0) mem_rvalid = 1'b1;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic cyc(input logic fr, input logic [3:0] nib);
        frame_n = fr;
        bus_in  = nib;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet(input int n, input string req, input string what);
        bit ok = 1'b1;
        for (int i = 0; i < n; i++) begin
            cyc(1'b1, 4'h3);
            if (bus_oe || mem_req) ok = 1'b0;
        end
        check(ok, req, what, {30'd0, bus_oe, mem_req}, 32'd0);
    endtask

    task automatic run_txn(input bit fwh, input bit wr, input logic [1:0] szc,
                           input int lat, input logic [31:0] addr, input logic [31:0] wd);
        int nbytes = fwh ? (szc == 2'd0 ? 1 : szc == 2'd1 ? 2 : 4) : 1;
        int anib = fwh ? 7 : 8;
        int waits;
        logic [31:0] mask = (nbytes == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * nbytes)) - 1);
        logic [31:0] exp_addr = fwh ? (addr & 32'h0FFF_FFFF) : addr;
        logic [31:0] rd = model(exp_addr);
        lat_cfg = lat;
        cyc(1'b0, fwh ? (wr ? 4'b1110 : 4'b1101) : 4'b0000);        // R2 R3
        cyc(1'b1, fwh ? STRAP : (wr ? 4'b0110 : 4'b0100));
        for (int i = 0; i < anib; i++) cyc(1'b1, exp_addr[4*(anib-1-i) +: 4]);
        if (fwh) cyc(1'b1, {2'b00, szc});
        if (wr) for (int i = 0; i < 2 * nbytes; i++) cyc(1'b1, wd[4*i +: 4]);
        check(mem_req === 1'b1, "R4", "request clock", {31'd0, mem_req}, 32'd1);
        check(mem_addr === exp_addr, "R4", "address", mem_addr, exp_addr);
        check(mem_we === wr, "R4", "direction", {31'd0, mem_we}, {31'd0, wr});
        check(mem_size === 2'(nbytes - 1), "R5", "size", {30'd0, mem_size}, nbytes - 1);
        check(bus_oe === 1'b0, "R7", "first turnaround floats", {31'd0, bus_oe}, 32'd0);
        if (wr) check((mem_wdata & mask) === (wd & mask), "R6", "write data", mem_wdata & mask, wd & mask);
        cyc(1'b1, 4'hF);
        check(bus_oe && bus_out === 4'hF, "R7", "second turnaround", {27'd0, bus_oe, bus_out}, 32'h1F);
        if (wr) waits = 0;
        else if (fwh) waits = (lat > 1) ? lat - 1 : 0;
        else waits = (lat - 1 > 2) ? lat - 1 : 2;
        for (int i = 0; i < waits; i++) begin
            cyc(1'b1, 4'hF);
            check(bus_oe && bus_out === 4'b0101, "R8", "wait sync", {27'd0, bus_oe, bus_out}, 32'h15);
        end
        cyc(1'b1, 4'hF);
        check(bus_oe && bus_out === 4'b0000, "R8", "ready sync", {27'd0, bus_oe, bus_out}, 32'h10);
        if (!wr) for (int i = 0; i < 2 * nbytes; i++) begin
            cyc(1'b1, 4'hF);
            check(bus_oe && bus_out === rd[4*i +: 4], "R9", "read nibble",
                  {27'd0, bus_oe, bus_out}, {27'd0, 1'b1, rd[4*i +: 4]});
        end
        cyc(1'b1, 4'hF);
        check(bus_oe && bus_out === 4'hF, "R9", "closing turnaround", {27'd0, bus_oe, bus_out}, 32'h1F);
        cyc(1'b1, 4'hF);
        check(bus_oe === 1'b0, "R9", "release after cycle", {31'd0, bus_oe}, 32'd0);
    endtask

    initial begin
        repeat (CLK_P * 20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        @(negedge clk);
        check(bus_oe === 1'b0 && mem_req === 1'b0, "R1", "in reset", {30'd0, bus_oe, mem_req}, 32'd0);
        @(negedge clk);
        rst_n = 1'b1;
        quiet(4, "R1", "after reset");

        for (int i = 0; i < NVEC; i++)
            run_txn(VEC[i][71], VEC[i][70], VEC[i][69:68], int'(VEC[i][67:64]),
                    VEC[i][63:32], VEC[i][31:0]);

        // R2: ID mismatch
        cyc(1'b0, 4'b1101); cyc(1'b1, STRAP ^ 4'h1);
        quiet(14, "R2", "foreign ID ignored");
        // R3: unknown START and non-memory cycle type
        cyc(1'b0, 4'b0101); cyc(1'b1, 4'b0100);
        quiet(14, "R3", "unknown START ignored");
        cyc(1'b0, 4'b0000); cyc(1'b1, 4'b0000);
        quiet(14, "R3", "non-memory type ignored");
        // R5: illegal size code
        cyc(1'b0, 4'b1101); cyc(1'b1, STRAP);
        for (int i = 0; i < 7; i++) cyc(1'b1, 4'h1);
        cyc(1'b1, 4'b0011);
        quiet(10, "R5", "illegal size ignored");

        // R10: abort in the address phase, then a clean cycle
        cyc(1'b0, 4'b1101); cyc(1'b1, STRAP); cyc(1'b1, 4'h7); cyc(1'b1, 4'h7);
        run_txn(1'b0, 1'b0, 2'd0, 0, 32'h0000_7777, 32'h0);
        // R10: abort while the target drives
        lat_cfg = 0;
        cyc(1'b0, 4'b0000); cyc(1'b1, 4'b0100);
        for (int i = 0; i < 8; i++) cyc(1'b1, 4'h2);
        cyc(1'b1, 4'hF);
        check(bus_oe === 1'b1, "R10", "driving before abort", {31'd0, bus_oe}, 32'd1);
        frame_n = 1'b0;
        bus_in  = 4'b1110;
        #1;
        check(bus_oe === 1'b0, "R10", "release with frame low", {31'd0, bus_oe}, 32'd0);
        run_txn(1'b1, 1'b1, 2'd0, 0, 32'h0000_0042, 32'h0000_00E7);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule